// File: doc/BRIEF.md
# Three-Address Integer ALU with Zero-True Comparisons

This block is the integer execute stage of a small register machine. Each cycle it may accept an operation code and two source operands, and one clock later it presents the result, ready to be written back to a destination register. It covers wrap-around arithmetic (add, subtract, multiply), unsigned quotient and remainder, four relational tests, and three bitwise operations.

The relational operations follow a zero-means-true convention: a relation that holds yields 0 and one that fails yields 1. A compare can therefore feed a jump-if-zero branch directly, with no inversion step. A divide or remainder by zero gives a result of 0 and raises a separate flag for that one operation. Shifts, carry or overflow flags and floating point are not part of this unit.

The divider comes in two variants, chosen by a parameter. One uses the native operator and the other uses an unrolled restoring array built by generate loops. Both variants produce the same results.

Top module: `alu3_core`

## Requirements
- R1: Op code 0 (add) returns a+b and op code 1 (sub) returns a-b, both modulo 2^DATA_W.
- R2: Op code 2 (mul) returns the low DATA_W bits of the product a*b.
- R3: Op code 3 (div) returns the unsigned quotient a/b, truncated, and op code 4 (mod) returns the unsigned remainder of a/b, for any nonzero b.
- R4: For op code 3 or 4 with b equal to 0, the result is 0 and div_zero is 1. For every other operation, and for div or mod with nonzero b, div_zero is 0.
- R5: Op code 5 (eq) returns 0 when a equals b and 1 otherwise. Op code 6 (neq) returns 0 when a differs from b and 1 otherwise.
- R6: Op code 7 (lt) returns 0 when a<b and op code 8 (gt) returns 0 when a>b, both comparing unsigned, and each returns 1 when its relation fails.
- R7: Op code 9 returns a AND b, op code 10 returns a OR b, and op code 11 returns NOT a, where the value of b has no effect on the result.
- R8: Op codes 12 to 15 return a result of 0 with div_zero 0.
- R9: An operation accepted with in_valid high at a rising edge appears on result and div_zero, with out_valid high, after that edge. After an edge with in_valid low, out_valid is low and result and div_zero keep their previous values.
- R10: While rst_n is low, out_valid, result and div_zero are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Operation code |
| opnd_a | input | DATA_W | First source operand |
| opnd_b | input | DATA_W | Second source operand |
| out_valid | output | 1 | Result registered from the previous cycle's operation |
| result | output | DATA_W | Operation result |
| div_zero | output | 1 | The delivered div or mod had a zero divisor |

## Verification
The bench builds the unit with DATA_W at 32 and the restoring-array divider selected. This brings the full-width boundary operands within reach: all-ones, 2^31, and products that overflow past the low word. It also exercises each generated divider stage on both its subtract and its keep path. Back-to-back operations, idle gaps and every unused op code are run through a scoreboard so that the one-cycle latency and the hold behaviour are checked alongside the values.

// File: rtl/alu3_pkg.sv
package alu3_pkg;

   localparam int unsigned OPC_W = 4;

   typedef enum logic [OPC_W-1:0] {
      OPC_ADD = 4'd0,
      OPC_SUB = 4'd1,
      OPC_MUL = 4'd2,
      OPC_DIV = 4'd3,
      OPC_MOD = 4'd4,
      OPC_EQ  = 4'd5,
      OPC_NEQ = 4'd6,
      OPC_LT  = 4'd7,
      OPC_GT  = 4'd8,
      OPC_AND = 4'd9,
      OPC_OR  = 4'd10,
      OPC_NOT = 4'd11
   } opc_e;

   localparam logic [OPC_W-1:0] OPC_LAST_USED = 4'd11;

endpackage

// File: rtl/alu3_arith.sv
module alu3_arith
   import alu3_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic [OPC_W-1:0]  op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] res
);

   logic [DATA_W-1:0] sum_w;
   logic [DATA_W-1:0] dif_w;
   logic [DATA_W-1:0] prd_w;

   assign sum_w = a + b;
   assign dif_w = a - b;
   assign prd_w = a * b;

   always_comb begin
      unique case (op)
         OPC_ADD: res = sum_w;
         OPC_SUB: res = dif_w;
         OPC_MUL: res = prd_w;
         default: res = '0;
      endcase
   end

endmodule

// File: rtl/alu3_divmod.sv
module alu3_divmod #(
   parameter int unsigned DATA_W        = 32,
   parameter bit          DIV_RESTORING = 1'b1
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] quo,
   output logic [DATA_W-1:0] rem,
   output logic              zero_div
);

   logic [DATA_W-1:0] raw_q;
   logic [DATA_W-1:0] raw_r;

   assign zero_div = (b == '0);

   generate
      if (DIV_RESTORING) begin : g_array
         logic [DATA_W-1:0] part [0:DATA_W];
         assign part[0] = '0;
         for (genvar k = 0; k < DATA_W; k++) begin : g_stage
            logic [DATA_W:0] trial;
            logic [DATA_W:0] diff;
            logic            take;
            assign trial = {part[k], a[DATA_W-1-k]};
            assign diff  = trial - {1'b0, b};
            assign take  = ~diff[DATA_W];
            assign raw_q[DATA_W-1-k] = take;
            assign part[k+1] = take ? diff[DATA_W-1:0] : trial[DATA_W-1:0];
         end
         assign raw_r = part[DATA_W];
      end else begin : g_native
         assign raw_q = zero_div ? '0 : a / b;
         assign raw_r = zero_div ? '0 : a % b;
      end
   endgenerate

   assign quo = zero_div ? '0 : raw_q;
   assign rem = zero_div ? '0 : raw_r;

endmodule

// File: rtl/alu3_cmp_logic.sv
module alu3_cmp_logic
   import alu3_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic [OPC_W-1:0]  op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] res
);

   localparam logic [DATA_W-1:0] HOLDS = '0;
   localparam logic [DATA_W-1:0] FAILS = {{(DATA_W-1){1'b0}}, 1'b1};

   logic same_w;
   logic below_w;
   logic above_w;

   assign same_w  = (a == b);
   assign below_w = (a < b);
   assign above_w = (a > b);

   always_comb begin
      unique case (op)
         OPC_EQ:  res = same_w  ? HOLDS : FAILS;
         OPC_NEQ: res = same_w  ? FAILS : HOLDS;
         OPC_LT:  res = below_w ? HOLDS : FAILS;
         OPC_GT:  res = above_w ? HOLDS : FAILS;
         OPC_AND: res = a & b;
         OPC_OR:  res = a | b;
         OPC_NOT: res = ~a;
         default: res = '0;
      endcase
   end

endmodule

// File: rtl/alu3_core.sv
module alu3_core
   import alu3_pkg::*;
#(
   parameter int unsigned DATA_W        = 32,
   parameter bit          DIV_RESTORING = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [3:0]        op,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   output logic              out_valid,
   output logic [DATA_W-1:0] result,
   output logic              div_zero
);

   initial begin : elab_chk
      if (DATA_W < 2)
         $fatal(1, "alu3_core: DATA_W must be at least 2");
      if (OPC_W != 4)
         $fatal(1, "alu3_core: op code width must be 4");
   end

   logic [DATA_W-1:0] arith_res;
   logic [DATA_W-1:0] cl_res;
   logic [DATA_W-1:0] quo_w;
   logic [DATA_W-1:0] rem_w;
   logic              dz_w;
   logic [DATA_W-1:0] nxt_res;
   logic              nxt_dz;

   alu3_arith #(.DATA_W(DATA_W)) u_arith (
      .op  (op),
      .a   (opnd_a),
      .b   (opnd_b),
      .res (arith_res)
   );

   alu3_divmod #(.DATA_W(DATA_W), .DIV_RESTORING(DIV_RESTORING)) u_divmod (
      .a        (opnd_a),
      .b        (opnd_b),
      .quo      (quo_w),
      .rem      (rem_w),
      .zero_div (dz_w)
   );

   alu3_cmp_logic #(.DATA_W(DATA_W)) u_cmp_logic (
      .op  (op),
      .a   (opnd_a),
      .b   (opnd_b),
      .res (cl_res)
   );

   always_comb begin
      nxt_dz = 1'b0;
      unique case (op)
         OPC_ADD, OPC_SUB, OPC_MUL: nxt_res = arith_res;
         OPC_DIV: begin
            nxt_res = quo_w;
            nxt_dz  = dz_w;
         end
         OPC_MOD: begin
            nxt_res = rem_w;
            nxt_dz  = dz_w;
         end
         OPC_EQ, OPC_NEQ, OPC_LT, OPC_GT,
         OPC_AND, OPC_OR, OPC_NOT:  nxt_res = cl_res;
         default:                   nxt_res = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         div_zero  <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result   <= nxt_res;
            div_zero <= nxt_dz;
         end
      end
   end

endmodule

// File: rtl/alu3_core_chk.sv
module alu3_core_chk
   import alu3_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [3:0]        op,
   input logic [DATA_W-1:0] opnd_a,
   input logic [DATA_W-1:0] opnd_b,
   input logic              out_valid,
   input logic [DATA_W-1:0] result,
   input logic              div_zero
);

   logic is_divop;
   logic is_cmp;
   assign is_divop = (op == OPC_DIV) || (op == OPC_MOD);
   assign is_cmp   = (op == OPC_EQ) || (op == OPC_NEQ) || (op == OPC_LT) || (op == OPC_GT);

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid) else $error("valid lost"); // R9
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(result) && $stable(div_zero))) else $error("idle change"); // R9
   AST_DZ_GIVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && div_zero) |-> (result == '0)) else $error("dz result"); // R4
   AST_DZ_ONLY_DIV: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !is_divop) |=> !div_zero) else $error("dz stray"); // R4
   AST_DZ_ZERO_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && is_divop) |=> (div_zero == ($past(opnd_b) == '0))) else $error("dz cause"); // R4
   AST_CMP_BINARY: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && is_cmp) |=> (result[DATA_W-1:1] == '0)) else $error("cmp width"); // R5
   AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (op > OPC_LAST_USED)) |=> (result == '0)) else $error("unused op"); // R8
   AST_NOT_IGNORES_B: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (op == OPC_NOT)) |=> (result == ~$past(opnd_a))) else $error("not op"); // R7

   always @(posedge clk) begin
      if (!rst_n) begin
         AST_RESET_CLEAR: assert (!out_valid && result == '0 && !div_zero) else $error("reset"); // R10
      end
   end

endmodule

bind alu3_core alu3_core_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/alu3_core_tb_top.sv
module alu3_core_tb_top;

   localparam int DW      = 32;
   localparam int CLK_PER = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [3:0]    op = '0;
   logic [DW-1:0] opnd_a = '0;
   logic [DW-1:0] opnd_b = '0;
   logic          out_valid;
   logic [DW-1:0] result;
   logic          div_zero;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   typedef struct {
      logic [DW-1:0] res;
      logic          dz;
      string         tag;
   } exp_t;

   exp_t sb_q[$];

   always #(CLK_PER/2) clk = ~clk;

   alu3_core #(.DATA_W(DW), .DIV_RESTORING(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
      .opnd_a(opnd_a), .opnd_b(opnd_b),
      .out_valid(out_valid), .result(result), .div_zero(div_zero)
   );

   function automatic exp_t model(input logic [3:0] c, input logic [DW-1:0] a,
                                  input logic [DW-1:0] b, input string tag);
      exp_t e;
      e.tag = tag;
      e.dz  = 1'b0;
      case (c)
         4'd0:  e.res = a + b;
         4'd1:  e.res = a - b;
         4'd2:  e.res = a * b;
         4'd3:  begin e.dz = (b == 0); e.res = (b == 0) ? '0 : a / b; end
         4'd4:  begin e.dz = (b == 0); e.res = (b == 0) ? '0 : a % b; end
         4'd5:  e.res = (a == b) ? 0 : 1;
         4'd6:  e.res = (a != b) ? 0 : 1;
         4'd7:  e.res = (a < b)  ? 0 : 1;
         4'd8:  e.res = (a > b)  ? 0 : 1;
         4'd9:  e.res = a & b;
         4'd10: e.res = a | b;
         4'd11: e.res = ~a;
         default: e.res = '0;
      endcase
      return e;
   endfunction

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [3:0] c, input logic [DW-1:0] a,
                        input logic [DW-1:0] b, input string tag);
      @(negedge clk);
      in_valid = 1'b1;
      op       = c;
      opnd_a   = a;
      opnd_b   = b;
      sb_q.push_back(model(c, a, b, tag));
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
      opnd_b   = 32'hDEAD_BEEF;
      op       = 4'd2;
   endtask

   // monitor: pops one expected item per delivered result
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (sb_q.size() == 0) begin
            check("R9 unexpected out_valid", 1, 0);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            check({e.tag, " result"}, result, e.res);
            check({e.tag, " div_zero"}, {31'd0, div_zero}, {31'd0, e.dz});
         end
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      logic [DW-1:0] held;
      repeat (2) @(negedge clk);
      check("R10 reset out_valid", {31'd0, out_valid}, 0);
      check("R10 reset result", result, 0);
      check("R10 reset div_zero", {31'd0, div_zero}, 0);
      rst_n = 1'b1;

      drive(4'd0, 32'hFFFF_FFFF, 32'd2, "R1 add wrap");
      drive(4'd0, 32'd100, 32'd23, "R1 add");
      drive(4'd1, 32'd3, 32'd5, "R1 sub wrap");
      drive(4'd2, 32'h0001_0000, 32'h0001_0000, "R2 mul overflow");
      drive(4'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 mul ones");
      drive(4'd2, 32'd7, 32'd6, "R2 mul");
      drive(4'd3, 32'd100, 32'd7, "R3 div");
      drive(4'd4, 32'd100, 32'd7, "R3 mod");
      drive(4'd3, 32'hFFFF_FFFF, 32'd2, "R3 div unsigned");
      drive(4'd4, 32'h8000_0000, 32'd3, "R3 mod unsigned");
      drive(4'd3, 32'd5, 32'd9, "R3 div small");
      drive(4'd3, 32'd5, 32'd0, "R4 div by zero");
      drive(4'd4, 32'd5, 32'd0, "R4 mod by zero");
      drive(4'd0, 32'd0, 32'd0, "R4 add no flag");
      drive(4'd5, 32'd5, 32'd5, "R5 eq true");
      drive(4'd5, 32'd5, 32'd6, "R5 eq false");
      drive(4'd6, 32'd5, 32'd6, "R5 neq true");
      drive(4'd6, 32'd5, 32'd5, "R5 neq false");
      drive(4'd7, 32'd1, 32'hFFFF_FFFF, "R6 lt unsigned");
      drive(4'd8, 32'd1, 32'hFFFF_FFFF, "R6 gt unsigned");
      drive(4'd7, 32'd4, 32'd4, "R6 lt equal");
      drive(4'd8, 32'd9, 32'd4, "R6 gt true");
      drive(4'd9, 32'hF0F0_1234, 32'h0FF0_FF00, "R7 and");
      drive(4'd10, 32'hF0F0_1234, 32'h0FF0_FF00, "R7 or");
      drive(4'd11, 32'h0F0F_00FF, 32'h1234_5678, "R7 not");
      drive(4'd11, 32'h0F0F_00FF, 32'hFFFF_FFFF, "R7 not other b");
      for (int c = 12; c < 16; c++)
         drive(c[3:0], 32'h1234_5678, 32'd0, "R8 unused op");
      for (int i = 0; i < 40; i++)
         drive(i[3:0] % 4'd12, 32'h9E37_79B9 * (i + 1), 32'h0000_1F3D * i, "R3 R6 sweep");

      drive(4'd4, 32'd29, 32'd8, "R9 before idle");
      idle();
      @(negedge clk);
      held = result;
      check("R9 idle out_valid", {31'd0, out_valid}, 0);
      check("R9 idle result held", held, 32'd5);
      idle();
      @(negedge clk);
      check("R9 idle result still held", result, 32'd5);
      drive(4'd1, 32'd10, 32'd4, "R9 resume");
      idle();
      repeat (3) @(negedge clk);
      check("R9 scoreboard drained", sb_q.size(), 0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule